// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider Chain

This block is the digital divider path of an integer-N frequency synthesizer. It has two dividers, and both run on one system clock. The feedback divider counts ticks from the VCO side (`vco_tick`). A 10/11 dual-modulus prescaler feeds a 9-bit main counter, and a 4-bit swallow counter chooses the modulus of each prescaler cycle. The first A prescaler cycles of a main period divide by 11 and the rest divide by 10, so one full period spans 10·(M+1)+A VCO ticks. An active-low enable can take the prescaler out of the path. The main counter then counts VCO ticks directly and the period is M+1.

The reference divider is a 6-bit counter that divides reference ticks (`ref_tick`) by R+1. Each divider emits a single-cycle pulse at the end of every period. The feedback pulse is `fp_pulse` and the reference pulse is `fc_pulse`. A phase comparator outside this block uses them. Each pulse has its own output enable. Clearing an enable silences that pulse but does not disturb the counting. New division values and the prescaler mode are captured only at the end of a period, so no period is ever cut short.

Top module: `swdiv_chain`

## Requirements
- R1: While `rst_n` is low, `fp_pulse` and `fc_pulse` are 0. Reset clears every counter, so the first `vco_tick` after reset ends a period at once and the first `ref_tick` after reset does the same. Each of these first ticks gives a pulse (when enabled) and loads the current settings.
- R2: With `dual_mod_en_n` = 0 and 0 <= `a_val` <= `m_val`, consecutive `fp_pulse` pulses are 10·(`m_val`+1)+`a_val` VCO ticks apart.
- R3: With `dual_mod_en_n` = 1, consecutive `fp_pulse` pulses are `m_val`+1 VCO ticks apart, and `a_val` has no effect.
- R4: Consecutive `fc_pulse` pulses are `r_val`+1 reference ticks apart, for `r_val` from 0 to 63.
- R5: A pulse is high for exactly one clock cycle. It is high in the cycle after the clock edge that sampled the tick completing the period.
- R6: `m_val`, `a_val` and `dual_mod_en_n` are sampled only at the end of a feedback period. A change made in the middle of a period first affects the next full period.
- R7: When `fp_en` is low at the edge where a feedback period ends, no `fp_pulse` is produced, and the feedback counting continues unchanged.
- R8: When `fc_en` is low at the edge where a reference period ends, no `fc_pulse` is produced, and the reference counting continues unchanged.
- R9: The counters advance only on cycles that carry a tick. Idle cycles between ticks stretch the pulse spacing in clock cycles but leave the spacing in ticks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_tick | input | 1 | One VCO-side input event per high cycle |
| ref_tick | input | 1 | One reference input event per high cycle |
| dual_mod_en_n | input | 1 | 0: 10/11 prescaler in path; 1: prescaler bypassed |
| m_val | input | 9 | Main counter setting M |
| a_val | input | 4 | Swallow counter setting A |
| r_val | input | 6 | Reference counter setting R |
| fp_en | input | 1 | Enable for the feedback pulse output |
| fc_en | input | 1 | Enable for the reference pulse output |
| fp_pulse | output | 1 | Feedback divider period-end pulse |
| fc_pulse | output | 1 | Reference divider period-end pulse |

## Verification
Each pulse is registered. It rises exactly one clock after the edge that sees the completing tick, and nothing else in the block carries a result. The bench samples every output on the falling edge and timestamps each pulse with a count of rising edges. It also records the cycle of the first tick it drives after reset. It then checks that the first pulse lands at that cycle plus one, and that differences between consecutive pulse timestamps equal the division times the tick stride. Enable and mid-period setting changes are applied on falling edges well away from any period end, so the period each change belongs to is unambiguous.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    parameter int unsigned SWD_M_W     = 9;
    parameter int unsigned SWD_A_W     = 4;
    parameter int unsigned SWD_R_W     = 6;
    parameter int unsigned SWD_PRE_LOW = 10;

    typedef enum logic {
        DIV_DUAL   = 1'b0,
        DIV_DIRECT = 1'b1
    } div_mode_e;

endpackage

// File: rtl/swdiv_main_path.sv
module swdiv_main_path
    import swdiv_pkg::*;
#(
    parameter int unsigned M_W     = SWD_M_W,
    parameter int unsigned A_W     = SWD_A_W,
    parameter int unsigned PRE_LOW = SWD_PRE_LOW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  div_mode_e      mode_i,
    input  logic [M_W-1:0] m_i,
    input  logic [A_W-1:0] a_i,
    input  logic           en_i,
    output logic           term_o,
    output logic [M_W-1:0] main_left_o
);

    localparam int unsigned PRE_HIGH = PRE_LOW + 1;
    localparam int unsigned P_W      = $clog2(PRE_HIGH);
    localparam logic [P_W-1:0] PRE_LONG  = P_W'(PRE_HIGH - 1);
    localparam logic [P_W-1:0] PRE_SHORT = P_W'(PRE_LOW - 1);

    typedef struct packed {
        logic [P_W-1:0] pre;
        logic [M_W-1:0] main;
        logic [A_W-1:0] swal;
        div_mode_e      mode;
        logic           term;
    } main_st_t;

    main_st_t st_d, st_q;
    logic     pre_done;
    logic [A_W-1:0] swal_nx;

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        pre_done  = (st_q.mode == DIV_DIRECT) || (st_q.pre == '0);
        swal_nx   = (st_q.swal != '0) ? st_q.swal - 1'b1 : '0;
        if (tick_i) begin
            if (!pre_done) begin
                st_d.pre = st_q.pre - 1'b1;
            end else if (st_q.main == '0) begin
                st_d.term = en_i;
                st_d.main = m_i;
                st_d.swal = a_i;
                st_d.mode = mode_i;
                st_d.pre  = (a_i != '0) ? PRE_LONG : PRE_SHORT;
            end else begin
                st_d.main = st_q.main - 1'b1;
                st_d.swal = swal_nx;
                st_d.pre  = (swal_nx != '0) ? PRE_LONG : PRE_SHORT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pre: '0, main: '0, swal: '0, mode: DIV_DUAL, term: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign term_o      = st_q.term;
    assign main_left_o = st_q.main;

endmodule

// File: rtl/swdiv_ref_path.sv
module swdiv_ref_path
    import swdiv_pkg::*;
#(
    parameter int unsigned R_W = SWD_R_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic [R_W-1:0] r_i,
    input  logic           en_i,
    output logic           term_o,
    output logic [R_W-1:0] ref_left_o
);

    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic           term;
    } ref_st_t;

    ref_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        if (tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.term = en_i;
                st_d.cnt  = r_i;
            end else begin
                st_d.cnt  = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, term: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign term_o     = st_q.term;
    assign ref_left_o = st_q.cnt;

endmodule

// File: rtl/swdiv_chain.sv
module swdiv_chain
    import swdiv_pkg::*;
#(
    parameter int unsigned M_W     = SWD_M_W,
    parameter int unsigned A_W     = SWD_A_W,
    parameter int unsigned R_W     = SWD_R_W,
    parameter int unsigned PRE_LOW = SWD_PRE_LOW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           ref_tick,
    input  logic           dual_mod_en_n,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic [R_W-1:0] r_val,
    input  logic           fp_en,
    input  logic           fc_en,
    output logic           fp_pulse,
    output logic           fc_pulse
);

    logic [M_W-1:0] main_left;
    logic [R_W-1:0] ref_left;
    div_mode_e      mode_sel;

    assign mode_sel = dual_mod_en_n ? DIV_DIRECT : DIV_DUAL;

    swdiv_main_path #(
        .M_W     (M_W),
        .A_W     (A_W),
        .PRE_LOW (PRE_LOW)
    ) u_main (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (vco_tick),
        .mode_i      (mode_sel),
        .m_i         (m_val),
        .a_i         (a_val),
        .en_i        (fp_en),
        .term_o      (fp_pulse),
        .main_left_o (main_left)
    );

    swdiv_ref_path #(
        .R_W (R_W)
    ) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (ref_tick),
        .r_i        (r_val),
        .en_i       (fc_en),
        .term_o     (fc_pulse),
        .ref_left_o (ref_left)
    );

endmodule

// File: rtl/swdiv_chain_chk.sv
module swdiv_chain_chk #(
    parameter int unsigned M_W = 9,
    parameter int unsigned R_W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           vco_tick,
    input logic           ref_tick,
    input logic           fp_en,
    input logic           fc_en,
    input logic [M_W-1:0] m_val,
    input logic           fp_pulse,
    input logic           fc_pulse,
    input logic [M_W-1:0] main_left,
    input logic [R_W-1:0] ref_left
);

    AST_FP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fp_pulse |-> $past(vco_tick)); // R5
    AST_FC_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fc_pulse |-> $past(ref_tick)); // R5
    AST_FP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fp_en) |-> !fp_pulse); // R7
    AST_FC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fc_en) |-> !fc_pulse); // R8
    AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_tick |=> $stable(main_left)); // R9
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(ref_left)); // R9
    AST_FP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fp_pulse |-> (main_left == $past(m_val))); // R6

endmodule

bind swdiv_chain swdiv_chain_chk #(
    .M_W (M_W),
    .R_W (R_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vco_tick  (vco_tick),
    .ref_tick  (ref_tick),
    .fp_en     (fp_en),
    .fc_en     (fc_en),
    .m_val     (m_val),
    .fp_pulse  (fp_pulse),
    .fc_pulse  (fc_pulse),
    .main_left (main_left),
    .ref_left  (ref_left)
);

// File: tb/swdiv_chain_bench.sv
`timescale 1ns/1ps
module swdiv_chain_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_tick = 1'b0;
    logic       ref_tick = 1'b0;
    logic       dual_mod_en_n = 1'b0;
    logic [8:0] m_val = '0;
    logic [3:0] a_val = '0;
    logic [5:0] r_val = '0;
    logic       fp_en = 1'b1;
    logic       fc_en = 1'b1;
    logic       fp_pulse, fc_pulse;

    swdiv_chain u_swdiv_chain (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .dual_mod_en_n(dual_mod_en_n), .m_val(m_val), .a_val(a_val),
        .r_val(r_val), .fp_en(fp_en), .fc_en(fc_en),
        .fp_pulse(fp_pulse), .fc_pulse(fc_pulse)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // tick driver
    bit tick_en = 0;
    int stride = 1;
    int ph = 0;
    int first_tick = 0;
    bit seen_first = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (tick_en) begin
                vco_tick = (ph == 0);
                ref_tick = (ph == 0);
                if (ph == 0 && !seen_first) begin
                    first_tick = cyc;
                    seen_first = 1;
                end
                ph = (ph + 1 >= stride) ? 0 : ph + 1;
            end else begin
                vco_tick = 1'b0;
                ref_tick = 1'b0;
            end
        end
    end

    // pulse monitor
    int fp_t[8];
    int fc_t[8];
    int fp_n = 0, fc_n = 0, fp_run = 0, fp_maxrun = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (fp_pulse) begin
                if (fp_n < 8) fp_t[fp_n] = cyc;
                fp_n++;
                fp_run++;
                if (fp_run > fp_maxrun) fp_maxrun = fp_run;
            end else begin
                fp_run = 0;
            end
            if (fc_pulse) begin
                if (fc_n < 8) fc_t[fc_n] = cyc;
                fc_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset(input logic byp, input int m, input int a, input int r, input int st);
        rst_n = 1'b0;
        tick_en = 0;
        dual_mod_en_n = byp;
        m_val = 9'(m);
        a_val = 4'(a);
        r_val = 6'(r);
        fp_en = 1'b1;
        fc_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(fp_pulse == 1'b0 && fc_pulse == 1'b0, "R1 reset outputs", {fp_pulse, fc_pulse}, 0);
        fp_n = 0; fc_n = 0; fp_run = 0; fp_maxrun = 0;
        seen_first = 0; ph = 0; stride = st;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tick_en = 1;
    endtask

    task automatic wait_fp(input int n);
        int lim = 0;
        while (fp_n < n && lim < 40000) begin
            @(negedge clk);
            lim++;
        end
        if (fp_n < n) chk(0, "timeout waiting fp_pulse", fp_n, n);
    endtask

    task automatic wait_fc(input int n);
        int lim = 0;
        while (fc_n < n && lim < 40000) begin
            @(negedge clk);
            lim++;
        end
        if (fc_n < n) chk(0, "timeout waiting fc_pulse", fc_n, n);
    endtask

    typedef struct packed {
        logic [0:0]  byp;
        logic [15:0] m;
        logic [15:0] a;
        logic [15:0] r;
        logic [15:0] st;
        logic [15:0] exp_fp;
        logic [15:0] exp_fc;
    } vec_t;

    localparam int VEC_N = 7;
    localparam vec_t VEC[VEC_N] = '{
        '{1'b0, 16'd3,   16'd2,  16'd4,  16'd1, 16'd42,   16'd5},
        '{1'b0, 16'd0,   16'd0,  16'd0,  16'd1, 16'd10,   16'd1},
        '{1'b1, 16'd5,   16'd0,  16'd2,  16'd1, 16'd6,    16'd3},
        '{1'b0, 16'd2,   16'd2,  16'd7,  16'd3, 16'd32,   16'd8},
        '{1'b1, 16'd0,   16'd9,  16'd1,  16'd2, 16'd1,    16'd2},
        '{1'b0, 16'd15,  16'd15, 16'd63, 16'd1, 16'd175,  16'd64},
        '{1'b0, 16'd511, 16'd15, 16'd5,  16'd1, 16'd5135, 16'd6}
    };

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // table of division settings; R2 dual modulus, R3 bypass, R4 reference, R9 strides
        for (int i = 0; i < VEC_N; i++) begin
            vec_t v = VEC[i];
            int ef = int'(v.exp_fp) * int'(v.st);
            int ec = int'(v.exp_fc) * int'(v.st);
            string tg = v.byp ? "R3 fp spacing" : "R2 fp spacing";
            apply_reset(v.byp, int'(v.m), int'(v.a), int'(v.r), int'(v.st));
            wait_fp(3);
            wait_fc(3);
            chk(fp_t[1] - fp_t[0] == ef, tg, fp_t[1] - fp_t[0], ef);
            chk(fp_t[2] - fp_t[1] == ef, v.st > 1 ? "R9 fp spacing with idle cycles" : tg,
                fp_t[2] - fp_t[1], ef);
            chk(fc_t[1] - fc_t[0] == ec, "R4 fc spacing", fc_t[1] - fc_t[0], ec);
            chk(fc_t[2] - fc_t[1] == ec, v.st > 1 ? "R9 fc spacing with idle cycles" : "R4 fc spacing",
                fc_t[2] - fc_t[1], ec);
        end

        // R1 priming and R5 pulse timing / width
        apply_reset(1'b0, 3, 2, 4, 1);
        wait_fp(2);
        wait_fc(1);
        chk(fp_t[0] == first_tick + 1, "R1 first fp after first tick", fp_t[0], first_tick + 1);
        chk(fc_t[0] == first_tick + 1, "R1 first fc after first tick", fc_t[0], first_tick + 1);
        chk(fp_maxrun == 1, "R5 fp pulse width", fp_maxrun, 1);

        // R6 settings change mid-period
        apply_reset(1'b0, 3, 2, 4, 1);
        wait_fp(1);
        repeat (10) @(negedge clk);
        m_val = 9'd1;
        a_val = 4'd1;
        wait_fp(3);
        chk(fp_t[1] - fp_t[0] == 42, "R6 period after mid change keeps old", fp_t[1] - fp_t[0], 42);
        chk(fp_t[2] - fp_t[1] == 21, "R6 next period uses new", fp_t[2] - fp_t[1], 21);
        repeat (5) @(negedge clk);
        dual_mod_en_n = 1'b1;
        wait_fp(5);
        chk(fp_t[3] - fp_t[2] == 21, "R6 mode change deferred", fp_t[3] - fp_t[2], 21);
        chk(fp_t[4] - fp_t[3] == 2, "R6 bypass after period end", fp_t[4] - fp_t[3], 2);

        // R7 fp enable gating
        apply_reset(1'b1, 4, 0, 4, 1);
        wait_fp(1);
        fp_en = 1'b0;
        while (cyc < fp_t[0] + 12) @(negedge clk);
        chk(fp_n == 1, "R7 fp suppressed while disabled", fp_n, 1);
        fp_en = 1'b1;
        wait_fp(2);
        chk(fp_t[1] - fp_t[0] == 15, "R7 fp phase kept", fp_t[1] - fp_t[0], 15);

        // R8 fc enable gating
        apply_reset(1'b1, 4, 0, 4, 1);
        wait_fc(1);
        fc_en = 1'b0;
        while (cyc < fc_t[0] + 12) @(negedge clk);
        chk(fc_n == 1, "R8 fc suppressed while disabled", fc_n, 1);
        fc_en = 1'b1;
        wait_fc(2);
        chk(fc_t[1] - fc_t[0] == 15, "R8 fc phase kept", fc_t[1] - fc_t[0], 15);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule